// File: doc/BRIEF.md
# Data Breakpoint Match Unit

This unit watches the load and store accesses of a processor core and compares each one against a small set of programmable data breakpoints. Each breakpoint has an address and an address mask. It also has a reference data value with a per-byte lane mask, and a mode word. The mode word enables the breakpoint, selects whether loads, stores or both qualify, and says whether the data value takes part in the match. When an enabled breakpoint matches, the unit raises a one-cycle debug request. With the request it gives the PC to report and a flag that says whether the request is precise.

A match that depends only on the address and the access type, or on store data, is known in the access cycle. It is reported as precise, with the PC of the access. A load whose match depends on the returned data cannot be resolved when it issues, because the core does not stall for it. The breakpoint then holds a pending slot with the load's tag and PC. The load-return beat that carries the same tag resolves the slot. If the data matches, the unit reports an imprecise request that carries the stored load PC.

Each breakpoint that generates a request sets a sticky status bit, and software clears that bit by writing a one to it. A small word-addressed register port gives access to all configuration and to the status.

Top module: `dbrk_match_unit`

## Requirements
- R1: A breakpoint whose enable bit (mode bit 0) is clear never matches, whatever the access.
- R2: With value compare off (mode bit 3 clear), a qualifying access gives dbg_req high with dbg_precise high in the cycle after the access. In that cycle dbg_pc equals the access PC.
- R3: An address bit whose mask bit is 1 is ignored in the compare. Every address bit whose mask bit is 0 must be equal to the breakpoint address.
- R4: Loads qualify only when the load-enable bit (mode bit 1) is set. Stores qualify only when the store-enable bit (mode bit 2) is set.
- R5: With value compare on, a store matches only when every byte lane whose bit is set in the lane mask (control bits 11:8, bit 8 = byte 0) equals the reference value. Such a match is precise.
- R6: With value compare on, a qualifying load raises no request in its own cycle. A later load-return beat with the same tag and matching lanes gives dbg_req with dbg_precise low in the following cycle, and dbg_pc then equals the load's PC.
- R7: A load-return beat whose tag differs from the pending tag neither resolves nor clears the pending compare.
- R8: Every breakpoint that generates a request sets its status bit, and that bit stays set until software writes 1 to it at the status address (index NUM_BP*4). Writing 0 leaves the bit unchanged.
- R9: When several breakpoints match at once, all of their status bits are set and a single one-cycle request is raised.
- R10: An imprecise request only ever comes from a breakpoint that has value compare enabled.
- R11: Register index 4*k+0 holds the address of breakpoint k, 4*k+1 its mask and 4*k+2 its reference value. Index 4*k+3 holds the control word: bit 0 enable, bit 1 load, bit 2 store, bit 3 value compare, bits 11:8 lane mask. All of these read back as written.
- R12: After reset there is no request, all status bits are zero and all configuration reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | A load or store access is presented |
| acc_is_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Access address |
| acc_wdata | input | DATA_W | Store data |
| acc_tag | input | TAG_W | Tag given to the load for its return beat |
| acc_pc | input | ADDR_W | PC of the accessing instruction |
| ld_ret_valid | input | 1 | Load-return beat present |
| ld_ret_tag | input | TAG_W | Tag of the returning load |
| ld_ret_data | input | DATA_W | Returned load data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data of the register at reg_addr, combinational |
| dbg_req | output | 1 | Debug exception request, one-cycle pulse |
| dbg_precise | output | 1 | Request is precise |
| dbg_pc | output | ADDR_W | PC to report with the request |
| bp_status | output | NUM_BP | Sticky per-breakpoint status |

## Verification
The assertions assume that an access and a load-return beat are never presented in the same cycle. They also assume that no register write changes the mode of a breakpoint in the cycle in which that breakpoint is resolving. The bench issues exactly one operation at a time, on separate cycles, with idle cycles between them and no register traffic during accesses. Load tags are drawn at random from a small range. Returns sometimes carry a foreign tag, and this exercises the rule that a pending compare waits for its own return.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;
    // control word bit positions
    localparam int CTL_EN       = 0;
    localparam int CTL_LD       = 1;
    localparam int CTL_ST       = 2;
    localparam int CTL_VC       = 3;
    localparam int CTL_LANE_LSB = 8;

    typedef struct packed {
        logic vc_en;
        logic st_en;
        logic ld_en;
        logic en;
    } bp_mode_t;
endpackage

// File: rtl/dbrk_regs.sv
module dbrk_regs
    import dbrk_pkg::*;
#(
    parameter int NUM_BP = 2,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_AW = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_wr,
    input  logic [REG_AW-1:0]               reg_addr,
    input  logic [DATA_W-1:0]               reg_wdata,
    input  logic [NUM_BP-1:0]               status_set,
    output logic [DATA_W-1:0]               reg_rdata,
    output logic [NUM_BP-1:0][ADDR_W-1:0]   cfg_addr,
    output logic [NUM_BP-1:0][ADDR_W-1:0]   cfg_amask,
    output logic [NUM_BP-1:0][DATA_W-1:0]   cfg_data,
    output logic [NUM_BP-1:0][DATA_W/8-1:0] cfg_lanes,
    output bp_mode_t [NUM_BP-1:0]           cfg_mode,
    output logic [NUM_BP-1:0]               status
);
    localparam int LANES     = DATA_W / 8;
    localparam int STAT_ADDR = NUM_BP * 4;

    typedef struct packed {
        logic [NUM_BP-1:0][ADDR_W-1:0] addr;
        logic [NUM_BP-1:0][ADDR_W-1:0] amask;
        logic [NUM_BP-1:0][DATA_W-1:0] data;
        logic [NUM_BP-1:0][LANES-1:0]  lanes;
        bp_mode_t [NUM_BP-1:0]         mode;
        logic [NUM_BP-1:0]             status;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        int sel;
        s_d = s_q;
        sel = int'(reg_addr >> 2);
        if (reg_wr) begin
            if (reg_addr == REG_AW'(STAT_ADDR)) begin
                s_d.status = s_q.status & ~reg_wdata[NUM_BP-1:0];
            end else if (reg_addr < REG_AW'(STAT_ADDR)) begin
                case (reg_addr[1:0])
                    2'd0: s_d.addr[sel]  = reg_wdata[ADDR_W-1:0];
                    2'd1: s_d.amask[sel] = reg_wdata[ADDR_W-1:0];
                    2'd2: s_d.data[sel]  = reg_wdata;
                    default: begin
                        s_d.mode[sel].en    = reg_wdata[CTL_EN];
                        s_d.mode[sel].ld_en = reg_wdata[CTL_LD];
                        s_d.mode[sel].st_en = reg_wdata[CTL_ST];
                        s_d.mode[sel].vc_en = reg_wdata[CTL_VC];
                        s_d.lanes[sel]      = reg_wdata[CTL_LANE_LSB +: LANES];
                    end
                endcase
            end
        end
        // a new hit wins over a clear in the same cycle
        s_d.status = s_d.status | status_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        int sel;
        sel = int'(reg_addr >> 2);
        reg_rdata = '0;
        if (reg_addr == REG_AW'(STAT_ADDR)) begin
            reg_rdata[NUM_BP-1:0] = s_q.status;
        end else if (reg_addr < REG_AW'(STAT_ADDR)) begin
            case (reg_addr[1:0])
                2'd0: reg_rdata[ADDR_W-1:0] = s_q.addr[sel];
                2'd1: reg_rdata[ADDR_W-1:0] = s_q.amask[sel];
                2'd2: reg_rdata = s_q.data[sel];
                default: begin
                    reg_rdata[CTL_EN] = s_q.mode[sel].en;
                    reg_rdata[CTL_LD] = s_q.mode[sel].ld_en;
                    reg_rdata[CTL_ST] = s_q.mode[sel].st_en;
                    reg_rdata[CTL_VC] = s_q.mode[sel].vc_en;
                    reg_rdata[CTL_LANE_LSB +: LANES] = s_q.lanes[sel];
                end
            endcase
        end
    end

    assign cfg_addr  = s_q.addr;
    assign cfg_amask = s_q.amask;
    assign cfg_data  = s_q.data;
    assign cfg_lanes = s_q.lanes;
    assign cfg_mode  = s_q.mode;
    assign status    = s_q.status;
endmodule

// File: rtl/dbrk_bp_cmp.sv
module dbrk_bp_cmp
    import dbrk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bp_mode_t            mode,
    input  logic [ADDR_W-1:0]   bp_addr,
    input  logic [ADDR_W-1:0]   bp_amask,
    input  logic [DATA_W-1:0]   bp_data,
    input  logic [DATA_W/8-1:0] bp_lanes,
    input  logic                acc_valid,
    input  logic                acc_is_store,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [DATA_W-1:0]   acc_wdata,
    input  logic [TAG_W-1:0]    acc_tag,
    input  logic [ADDR_W-1:0]   acc_pc,
    input  logic                ret_valid,
    input  logic [TAG_W-1:0]    ret_tag,
    input  logic [DATA_W-1:0]   ret_data,
    output logic                hit_now,
    output logic                hit_late,
    output logic [ADDR_W-1:0]   late_pc
);
    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] pc;
    } pend_t;

    pend_t p_d, p_q;

    function automatic logic lanes_ok(input logic [DATA_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (bp_lanes[i] && (v[8*i +: 8] != bp_data[8*i +: 8])) ok = 1'b0;
        end
        return ok;
    endfunction

    logic type_ok, addr_ok, qual, arm, resolve;

    always_comb begin
        type_ok  = acc_is_store ? mode.st_en : mode.ld_en;
        addr_ok  = ((acc_addr ^ bp_addr) & ~bp_amask) == '0;
        qual     = acc_valid && mode.en && type_ok && addr_ok;
        hit_now  = qual && (!mode.vc_en || (acc_is_store && lanes_ok(acc_wdata)));
        arm      = qual && mode.vc_en && !acc_is_store;
        resolve  = p_q.vld && ret_valid && (ret_tag == p_q.tag);
        hit_late = resolve && mode.en && mode.vc_en && lanes_ok(ret_data);
        late_pc  = p_q.pc;

        p_d = p_q;
        if (resolve) p_d.vld = 1'b0;
        if (arm) begin
            p_d.vld = 1'b1;
            p_d.tag = acc_tag;
            p_d.pc  = acc_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end
endmodule

// File: rtl/dbrk_report.sv
module dbrk_report #(
    parameter int NUM_BP = 2,
    parameter int ADDR_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BP-1:0]             hit_now,
    input  logic [NUM_BP-1:0]             hit_late,
    input  logic [NUM_BP-1:0][ADDR_W-1:0] late_pc,
    input  logic [ADDR_W-1:0]             acc_pc,
    output logic [NUM_BP-1:0]             status_set,
    output logic                          dbg_req,
    output logic                          dbg_precise,
    output logic [ADDR_W-1:0]             dbg_pc
);
    typedef struct packed {
        logic              req;
        logic              precise;
        logic [ADDR_W-1:0] pc;
    } rep_t;

    rep_t r_d, r_q;

    always_comb begin
        r_d        = '0;
        status_set = hit_now | hit_late;
        if (|hit_now) begin
            r_d.req     = 1'b1;
            r_d.precise = 1'b1;
            r_d.pc      = acc_pc;
        end else if (|hit_late) begin
            r_d.req = 1'b1;
            for (int i = NUM_BP - 1; i >= 0; i--) begin
                if (hit_late[i]) r_d.pc = late_pc[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dbg_req     = r_q.req;
    assign dbg_precise = r_q.precise;
    assign dbg_pc      = r_q.pc;
endmodule

// File: rtl/dbrk_match_unit.sv
module dbrk_match_unit
    import dbrk_pkg::*;
#(
    parameter int NUM_BP = 2,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 3,
    localparam int REG_AW = $clog2(NUM_BP * 4 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_is_store,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [TAG_W-1:0]  acc_tag,
    input  logic [ADDR_W-1:0] acc_pc,
    input  logic              ld_ret_valid,
    input  logic [TAG_W-1:0]  ld_ret_tag,
    input  logic [DATA_W-1:0] ld_ret_data,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              dbg_req,
    output logic              dbg_precise,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [NUM_BP-1:0] bp_status
);
    localparam int LANES = DATA_W / 8;

    logic [NUM_BP-1:0][ADDR_W-1:0] cfg_addr, cfg_amask, late_pc;
    logic [NUM_BP-1:0][DATA_W-1:0] cfg_data;
    logic [NUM_BP-1:0][LANES-1:0]  cfg_lanes;
    bp_mode_t [NUM_BP-1:0]         cfg_mode;
    logic [NUM_BP-1:0]             cfg_vc, hit_now, hit_late, status_set;

    dbrk_regs #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .status_set(status_set), .reg_rdata(reg_rdata),
        .cfg_addr(cfg_addr), .cfg_amask(cfg_amask), .cfg_data(cfg_data),
        .cfg_lanes(cfg_lanes), .cfg_mode(cfg_mode), .status(bp_status)
    );

    for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
        assign cfg_vc[g] = cfg_mode[g].vc_en;
        dbrk_bp_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) i_cmp (
            .clk(clk), .rst_n(rst_n), .mode(cfg_mode[g]),
            .bp_addr(cfg_addr[g]), .bp_amask(cfg_amask[g]),
            .bp_data(cfg_data[g]), .bp_lanes(cfg_lanes[g]),
            .acc_valid(acc_valid), .acc_is_store(acc_is_store),
            .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_tag(acc_tag),
            .acc_pc(acc_pc), .ret_valid(ld_ret_valid), .ret_tag(ld_ret_tag),
            .ret_data(ld_ret_data), .hit_now(hit_now[g]),
            .hit_late(hit_late[g]), .late_pc(late_pc[g])
        );
    end

    dbrk_report #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W)) i_report (
        .clk(clk), .rst_n(rst_n), .hit_now(hit_now), .hit_late(hit_late),
        .late_pc(late_pc), .acc_pc(acc_pc), .status_set(status_set),
        .dbg_req(dbg_req), .dbg_precise(dbg_precise), .dbg_pc(dbg_pc)
    );
endmodule

// File: rtl/dbrk_checker.sv
module dbrk_checker #(
    parameter int NUM_BP = 2,
    parameter int ADDR_W = 32,
    parameter int REG_AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_pc,
    input logic              ld_ret_valid,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic              dbg_req,
    input logic              dbg_precise,
    input logic [ADDR_W-1:0] dbg_pc,
    input logic [NUM_BP-1:0] bp_status,
    input logic [NUM_BP-1:0] cfg_vc
);
    localparam int STAT_ADDR = NUM_BP * 4;

    AST_PRECISE_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && dbg_precise) |-> ($past(acc_valid) && dbg_pc == $past(acc_pc))); // R2

    AST_LATE_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && !dbg_precise) |-> $past(ld_ret_valid)); // R6

    AST_LATE_NEEDS_VC: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && !dbg_precise) |-> ($past(cfg_vc) != '0)); // R10

    AST_REQ_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> (bp_status != '0)); // R8

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(reg_wr) && $past(reg_addr) == REG_AW'(STAT_ADDR))
        |-> (($past(bp_status) & ~bp_status) == '0)); // R8
endmodule

bind dbrk_match_unit dbrk_checker #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) i_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_pc(acc_pc),
    .ld_ret_valid(ld_ret_valid), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .dbg_req(dbg_req), .dbg_precise(dbg_precise), .dbg_pc(dbg_pc),
    .bp_status(bp_status), .cfg_vc(cfg_vc)
);

// File: tb/test_dbrk_match_unit.sv
`timescale 1ns/1ps
module test_dbrk_match_unit;
    localparam int NB = 2;

    logic        clk = 0, rst_n = 0;
    logic        acc_valid = 0, acc_is_store = 0;
    logic [31:0] acc_addr = 0, acc_wdata = 0, acc_pc = 0;
    logic [2:0]  acc_tag = 0, ld_ret_tag = 0;
    logic        ld_ret_valid = 0;
    logic [31:0] ld_ret_data = 0;
    logic        reg_wr = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        dbg_req, dbg_precise;
    logic [31:0] dbg_pc;
    logic [1:0]  bp_status;

    dbrk_match_unit i_dbrk_match_unit (.*);

    always #2 clk = ~clk;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // bench reference state
    bit [31:0] m_addr[NB], m_mask[NB], m_data[NB];
    bit [3:0]  m_mode[NB]; // 0 en,1 ld,2 st,3 vc
    bit [3:0]  m_lanes[NB];
    bit [1:0]  m_stat;
    bit        m_pv[NB];
    bit [2:0]  m_pt[NB];
    bit [31:0] m_pp[NB];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit lane_eq(int k, bit [31:0] v);
        for (int i = 0; i < 4; i++)
            if (m_lanes[k][i] && v[8*i +: 8] != m_data[k][8*i +: 8]) return 0;
        return 1;
    endfunction

    task automatic wr(input int a, input bit [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        if (a == 4*NB) m_stat &= ~d[1:0];
        else begin
            case (a % 4)
                0: m_addr[a/4] = d;
                1: m_mask[a/4] = d;
                2: m_data[a/4] = d;
                default: begin m_mode[a/4] = d[3:0]; m_lanes[a/4] = d[11:8]; end
            endcase
        end
    endtask

    task automatic rd(input int a, output bit [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 d = reg_rdata;
    endtask

    task automatic chk_out(string req, bit exp_req, bit exp_prec, bit [31:0] exp_pc);
        check(req, dbg_req, exp_req);
        if (exp_req) begin
            check(req, dbg_precise, exp_prec);
            check(req, dbg_pc, exp_pc);
        end
        check(req, bp_status, m_stat);
    endtask

    task automatic access(string req, bit st, bit [31:0] a, bit [31:0] d, bit [2:0] t, bit [31:0] pc);
        bit [1:0] hit = 0;
        for (int k = 0; k < NB; k++) begin
            bit q;
            q = m_mode[k][0] && (st ? m_mode[k][2] : m_mode[k][1])
                && (((a ^ m_addr[k]) & ~m_mask[k]) == 0);
            if (q && (!m_mode[k][3] || (st && lane_eq(k, d)))) hit[k] = 1;
            if (q && m_mode[k][3] && !st) begin m_pv[k] = 1; m_pt[k] = t; m_pp[k] = pc; end
        end
        @(negedge clk);
        acc_valid = 1; acc_is_store = st; acc_addr = a; acc_wdata = d; acc_tag = t; acc_pc = pc;
        @(negedge clk);
        acc_valid = 0;
        m_stat |= hit;
        chk_out(req, hit != 0, 1, pc);
        @(negedge clk);
        check(req, dbg_req, 0); // single-cycle pulse
    endtask

    task automatic ret(string req, bit [2:0] t, bit [31:0] d);
        bit [1:0] hit = 0;
        bit [31:0] pc = 0;
        for (int k = NB - 1; k >= 0; k--) begin
            if (m_pv[k] && m_pt[k] == t) begin
                m_pv[k] = 0;
                if (m_mode[k][0] && m_mode[k][3] && lane_eq(k, d)) begin hit[k] = 1; pc = m_pp[k]; end
            end
        end
        @(negedge clk);
        ld_ret_valid = 1; ld_ret_tag = t; ld_ret_data = d;
        @(negedge clk);
        ld_ret_valid = 0;
        m_stat |= hit;
        chk_out(req, hit != 0, 0, pc);
    endtask

    task automatic cfg(int k, bit [31:0] a, bit [31:0] msk, bit [31:0] d, bit [11:0] ctl);
        wr(4*k, a); wr(4*k+1, msk); wr(4*k+2, d); wr(4*k+3, {20'd0, ctl});
    endtask

    initial begin
        #(4*200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit [31:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        check("R12", dbg_req, 0);
        check("R12", bp_status, 0);
        rd(3, v); check("R12", v, 0);
        rd(4*NB, v); check("R12", v, 0);

        // R11 readback
        cfg(0, 32'h1000_0040, 32'h0000_000F, 32'hAABB_CCDD, 12'h00B);
        rd(0, v); check("R11", v, 32'h1000_0040);
        rd(1, v); check("R11", v, 32'h0000_000F);
        rd(2, v); check("R11", v, 32'hAABB_CCDD);
        rd(3, v); check("R11", v, 32'h00B);

        // R1 disabled breakpoint
        wr(3, 32'h002);
        access("R1", 0, 32'h1000_0040, 0, 1, 32'h400);
        // R2 precise without value compare
        wr(3, 32'h003);
        access("R2", 0, 32'h1000_0040, 0, 1, 32'h404);
        // R8 sticky, W1C with zero leaving it set, then clear
        access("R8", 0, 32'h2000_0000, 0, 1, 32'h408);
        wr(4*NB, 0); check("R8", bp_status, 2'b01);
        wr(4*NB, 1); check("R8", bp_status, 2'b00);
        // R3 mask
        access("R3", 0, 32'h1000_004C, 0, 1, 32'h40C);
        access("R3", 0, 32'h1000_0050, 0, 1, 32'h410);
        wr(4*NB, 3);
        // R4 type select: load-only, store ignored; store-only hits store
        access("R4", 1, 32'h1000_0040, 0, 1, 32'h414);
        wr(3, 32'h005);
        access("R4", 1, 32'h1000_0040, 0, 1, 32'h418);
        access("R4", 0, 32'h1000_0040, 0, 1, 32'h41C);
        wr(4*NB, 3);
        // R5 store value compare on lanes 0,1
        wr(3, 32'h30D);
        access("R5", 1, 32'h1000_0040, 32'h1234_CCDD, 1, 32'h420);
        access("R5", 1, 32'h1000_0040, 32'h1234_CCDE, 1, 32'h424);
        wr(4*NB, 3);
        // R6 / R7 load value compare
        wr(3, 32'h30B);
        access("R6", 0, 32'h1000_0040, 0, 3'd5, 32'h428);
        ret("R7", 3'd2, 32'h0000_CCDD);
        ret("R6", 3'd5, 32'h0000_CCDD);
        ret("R6", 3'd5, 32'h0000_CCDD); // slot already consumed
        wr(4*NB, 3);
        // R9 two breakpoints on the same access
        wr(3, 32'h003);
        cfg(1, 32'h1000_0040, 0, 0, 12'h003);
        access("R9", 0, 32'h1000_0040, 0, 1, 32'h42C);
        check("R9", bp_status, 2'b11);
        wr(4*NB, 3);

        // constrained random mix; R10 is also covered by the checker
        for (int it = 0; it < 600; it++) begin
            if (it % 40 == 0) begin
                for (int k = 0; k < NB; k++)
                    cfg(k, $urandom & 32'hFFFF_FFF0, $urandom & 32'h0000_01F0, $urandom,
                        12'(($urandom & 12'hF0E) | 12'(($urandom % 4) != 0)));
                wr(4*NB, 3);
            end
            begin
                int op = $urandom % 3;
                int k = $urandom % NB;
                bit [31:0] a = (($urandom % 4) == 0) ? $urandom : (m_addr[k] ^ ($urandom & 32'h3F0));
                bit [31:0] d = (($urandom % 2) == 0) ? m_data[k] ^ (32'h1 << ($urandom % 32)) : m_data[k];
                if (op == 2) ret("RND", 3'($urandom % 4), d);
                else access("RND", op == 1, a, d, 3'($urandom % 4), $urandom);
                if (($urandom % 8) == 0) wr(4*NB, $urandom & 3);
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule